// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Core and Line Fan-Out

This block collects 32 level-sensitive interrupt requests and steers them to a grid of 16 outputs, one output for each pairing of 4 processor cores with 4 request lines per core. Output index `4*core + line` carries the pairing. Software gives every input a route byte, whose low nibble picks target cores and whose high nibble picks target lines. A global enable mask, changed through separate set and clear words, gates the inputs into a pending vector. The block exposes that vector through a masked status word and a per-core status word for each core.

The input levels are captured in a register once per clock. The pending vector, the per-core status and all outputs are combinational functions of the captured levels, the mask and the route bytes, so the outputs follow any register write or input change one clock later. An output for a core/line pair is the AND of two separate facts: some pending input selects that core, and some pending input selects that line. These two inputs do not have to be the same input.

The bus is single-cycle. The register decoder sorts every access into one access class of the enumerated type `acc_kind_e`: `ACC_NONE` (unmapped or misaligned), `ACC_ROUTE`, `ACC_STATUS`, `ACC_EN`, `ACC_EN_SET`, `ACC_EN_CLR` and `ACC_CORE`. This classification is the only selection step. Each strobed access goes from idle to its class for one cycle and then back to idle. There are no multi-cycle sequences. A read returns its data one cycle after the strobe in the registered read port.

Top module: `irq_route_hub`

## Requirements
- R1: After reset, all route bytes, the enable mask, the captured input levels, the read data and all 16 outputs are zero.
- R2: A byte access (size code 0; size codes: 0 byte, 1 half, 2 word, 3 reserved) at address n in 0x00..0x1F writes or reads the route byte of input n. Bits 3:0 of the byte select cores 0..3, and bits 7:4 select lines 0..3.
- R3: An access with any size other than byte to addresses 0x00..0x1F reads 0 and leaves every route byte unchanged.
- R4: A word write to 0x28 ORs the written value into the enable mask.
- R5: A word write to 0x2C clears the enable-mask bits that are set in the written value.
- R6: A word read of 0x24 returns the enable mask. A word read of 0x20 returns the captured input levels ANDed with the mask. Input levels are captured on each clock edge and are not latched beyond the current level.
- R7: A word read of 0x40 + 8*c returns the pending inputs whose route byte has core bit c set.
- R8: Output 4*c + l is high exactly when core c's status is nonzero and at least one pending input has line bit l set. It updates one clock after the register write or input change that affects it.
- R9: Reads of unmapped, misaligned or wrongly sized locations return 0, and writes to them change nothing. Examples are a word at 0x22, 0x30 or 0x44, and a byte at 0x24.
- R10: Writes to the status word (0x20) or a per-core status word have no lasting effect. The next read returns the computed value.
- R11: Read data loads only on a read strobe and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 16 | Core/line request outputs, index 4*core+line |

## Verification
The fan-out is tried with single inputs that route to one core and one line, which shows that the nibbles are decoded in the right positions. It is also tried with pairs of inputs in which one input names only a core and the other names only a line. An output that rises in this case separates the AND-of-two-ORs rule from a per-input match. Masking patterns that switch on and off while the input levels stay fixed separate the enable path from the input capture. Random mixes of input changes, route writes, mask writes and reads at every address and size compare each output and each read value against a bench model.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ROUTE,
        ACC_STATUS,
        ACC_EN,
        ACC_EN_SET,
        ACC_EN_CLR,
        ACC_CORE
    } acc_kind_e;

    localparam int OFS_STATUS  = 'h20;
    localparam int OFS_EN      = 'h24;
    localparam int OFS_EN_SET  = 'h28;
    localparam int OFS_EN_CLR  = 'h2C;
    localparam int OFS_CORE    = 'h40;
    localparam int CORE_STRIDE = 8;

endpackage

// File: rtl/irq_route_dec.sv
module irq_route_dec
    import irq_route_pkg::*;
#(
    parameter int N_IN   = 32,
    parameter int N_CORE = 4,
    parameter int ADDR_W = 7,
    parameter int SEL_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output acc_kind_e         kind,
    output logic [SEL_W-1:0]  sel
);
    localparam logic [ADDR_W-1:0] A_ROUTE_END = ADDR_W'(N_IN);
    localparam logic [ADDR_W-1:0] A_STATUS    = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_EN        = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_EN_SET    = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR    = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_CORE      = ADDR_W'(OFS_CORE);
    localparam logic [ADDR_W-1:0] A_CORE_END  = ADDR_W'(OFS_CORE + CORE_STRIDE * N_CORE);

    acc_size_e         sz;
    logic [ADDR_W-1:0] core_ofs;

    assign sz       = acc_size_e'(size);
    assign core_ofs = addr - A_CORE;

    always_comb begin
        kind = ACC_NONE;
        sel  = '0;
        unique case (sz)
            SZ_BYTE: begin
                if (addr < A_ROUTE_END) begin
                    kind = ACC_ROUTE;
                    sel  = SEL_W'(addr);
                end
            end
            SZ_WORD: begin
                if (addr[1:0] == 2'b00) begin
                    if (addr >= A_CORE && addr < A_CORE_END) begin
                        if (core_ofs[2:0] == 3'b000) begin
                            kind = ACC_CORE;
                            sel  = SEL_W'(core_ofs[ADDR_W-1:3]);
                        end
                    end else if (addr == A_STATUS) begin
                        kind = ACC_STATUS;
                    end else if (addr == A_EN) begin
                        kind = ACC_EN;
                    end else if (addr == A_EN_SET) begin
                        kind = ACC_EN_SET;
                    end else if (addr == A_EN_CLR) begin
                        kind = ACC_EN_CLR;
                    end
                end
            end
            default: begin
                kind = ACC_NONE;
            end
        endcase
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int N_IN   = 32,
    parameter int N_CORE = 4,
    parameter int RW     = 8,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid,
    input  logic                         we,
    input  acc_kind_e                    kind,
    input  logic [SEL_W-1:0]             sel,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [N_IN-1:0]              irq_in,
    input  logic [N_IN-1:0]              pend,
    input  logic [N_CORE-1:0][N_IN-1:0]  core_stat,
    output logic [N_IN-1:0][RW-1:0]      route,
    output logic [N_IN-1:0]              ien,
    output logic [N_IN-1:0]              pin_q,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1;

    logic [DATA_W-1:0] rd_mux;
    logic [N_IN-1:0]   wmask;

    assign wmask = wdata[N_IN-1:0];

    always_comb begin
        rd_mux = '0;
        unique case (kind)
            ACC_ROUTE:  rd_mux = DATA_W'(route[sel]);
            ACC_STATUS: rd_mux = DATA_W'(pend);
            ACC_EN:     rd_mux = DATA_W'(ien);
            ACC_CORE:   rd_mux = DATA_W'(core_stat[sel[CORE_W-1:0]]);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route   <= '0;
            ien     <= '0;
            pin_q   <= '0;
            rd_data <= '0;
        end else begin
            pin_q <= irq_in;
            if (valid && we) begin
                unique case (kind)
                    ACC_ROUTE:  route[sel] <= wdata[RW-1:0];
                    ACC_EN_SET: ien <= ien | wmask;
                    ACC_EN_CLR: ien <= ien & ~wmask;
                    default:    ;
                endcase
            end
            if (valid && !we) begin
                rd_data <= rd_mux;
            end
        end
    end

    a_r4_set_ors_in: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && we && kind == ACC_EN_SET) |=> ((ien & $past(wmask)) == $past(wmask)));

    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && we && kind == ACC_EN_CLR) |=> ((ien & $past(wmask)) == '0));

    a_r3_route_only_by_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (!(valid && we && kind == ACC_ROUTE)) |=> $stable(route));

    a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !we && kind == ACC_NONE) |=> (rd_data == '0));

    a_r10_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && we && (kind == ACC_STATUS || kind == ACC_CORE)) |=> $stable(ien));

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(valid && !we)) |=> $stable(rd_data));
endmodule

// File: rtl/irq_route_fanin.sv
module irq_route_fanin #(
    parameter int N_IN   = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4,
    parameter int RW     = 8,
    parameter int N_OUT  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_IN-1:0][RW-1:0]      route,
    input  logic [N_IN-1:0]              pend,
    output logic [N_CORE-1:0][N_IN-1:0]  core_stat,
    output logic [N_OUT-1:0]             irq_out
);
    logic [N_LINE-1:0][N_IN-1:0] line_stat;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        for (genvar gc = 0; gc < N_CORE; gc++) begin : g_core_bit
            assign core_stat[gc][gi] = pend[gi] & route[gi][gc];
        end
        for (genvar gl = 0; gl < N_LINE; gl++) begin : g_line_bit
            assign line_stat[gl][gi] = pend[gi] & route[gi][N_CORE + gl];
        end
    end

    for (genvar gc = 0; gc < N_CORE; gc++) begin : g_pair_c
        for (genvar gl = 0; gl < N_LINE; gl++) begin : g_pair_l
            assign irq_out[gc * N_LINE + gl] = (|core_stat[gc]) & (|line_stat[gl]);
        end

        a_r8_row_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
            (|irq_out[gc * N_LINE +: N_LINE]) |-> (core_stat[gc] != '0));
    end
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
    import irq_route_pkg::*;
#(
    parameter int N_IN   = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IN-1:0]            irq_in,
    input  logic                       bus_valid,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [1:0]                 bus_size,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [N_CORE*N_LINE-1:0]   irq_out
);
    localparam int RW    = N_CORE + N_LINE;
    localparam int SEL_W = $clog2(N_IN);
    localparam int N_OUT = N_CORE * N_LINE;

    acc_kind_e                   kind;
    logic [SEL_W-1:0]            sel;
    logic [N_IN-1:0][RW-1:0]     route;
    logic [N_IN-1:0]             ien;
    logic [N_IN-1:0]             pin_q;
    logic [N_IN-1:0]             pend;
    logic [N_CORE-1:0][N_IN-1:0] core_stat;

    assign pend = pin_q & ien;

    irq_route_dec #(
        .N_IN(N_IN), .N_CORE(N_CORE), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_dec (
        .addr(bus_addr), .size(bus_size), .kind(kind), .sel(sel)
    );

    irq_route_regs #(
        .N_IN(N_IN), .N_CORE(N_CORE), .RW(RW), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .we(bus_we),
        .kind(kind), .sel(sel), .wdata(bus_wdata), .irq_in(irq_in),
        .pend(pend), .core_stat(core_stat), .route(route), .ien(ien),
        .pin_q(pin_q), .rd_data(bus_rdata)
    );

    irq_route_fanin #(
        .N_IN(N_IN), .N_CORE(N_CORE), .N_LINE(N_LINE), .RW(RW), .N_OUT(N_OUT)
    ) u_fanin (
        .clk(clk), .rst_n(rst_n), .route(route), .pend(pend),
        .core_stat(core_stat), .irq_out(irq_out)
    );

    a_r8_quiet_without_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq_out == '0));

    a_r6_mask_gates_status: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> (core_stat == '0));
endmodule

// File: tb/sim_irq_route_hub.sv
module sim_irq_route_hub;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        bus_valid, bus_we;
    logic [6:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic [15:0] irq_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0]  m_route [32];
    logic [31:0] m_en, m_pin;

    always #4 clk = ~clk;

    irq_route_hub u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] m_core(int c);
        logic [31:0] r = '0;
        logic [31:0] p = m_pin & m_en;
        for (int i = 0; i < 32; i++) if (p[i] && m_route[i][c]) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] m_out();
        logic [15:0] o = '0;
        logic [3:0]  ln = '0;
        logic [31:0] p = m_pin & m_en;
        for (int l = 0; l < 4; l++)
            for (int i = 0; i < 32; i++) if (p[i] && m_route[i][4 + l]) ln[l] = 1'b1;
        for (int c = 0; c < 4; c++)
            for (int l = 0; l < 4; l++) o[4 * c + l] = (m_core(c) != 0) && ln[l];
        return o;
    endfunction

    function automatic logic [31:0] m_read(logic [6:0] a, logic [1:0] s);
        if (s == 2'd0) return (a < 7'd32) ? {24'h0, m_route[a[4:0]]} : 32'h0;
        if (s != 2'd2 || a[1:0] != 2'b00) return 32'h0;
        if (a >= 7'h40 && a < 7'h60) return (a[2:0] == 3'b000) ? m_core(int'(a[4:3])) : 32'h0;
        if (a == 7'h20) return m_pin & m_en;
        if (a == 7'h24) return m_en;
        return 32'h0;
    endfunction

    task automatic m_write(logic [6:0] a, logic [1:0] s, logic [31:0] d);
        if (s == 2'd0 && a < 7'd32) m_route[a[4:0]] = d[7:0];
        else if (s == 2'd2 && a == 7'h28) m_en = m_en | d;
        else if (s == 2'd2 && a == 7'h2C) m_en = m_en & ~d;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_op(bit we, logic [6:0] a, logic [1:0] s, logic [31:0] d, string tag);
        logic [31:0] exp_rd;
        logic [31:0] old_rd;
        exp_rd = m_read(a, s);
        old_rd = bus_rdata;
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_size = s; bus_wdata = d;
        @(posedge clk);
        if (we) m_write(a, s, d);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        if (we) check({"R11 hold on write, ", tag}, bus_rdata, old_rd);
        else    check(tag, bus_rdata, exp_rd);
        check("R8 outputs after access", {16'h0, irq_out}, {16'h0, m_out()});
    endtask

    task automatic set_pins(logic [31:0] v);
        irq_in = v;
        @(posedge clk);
        m_pin = v;
        @(negedge clk);
        check("R8 outputs after input change", {16'h0, irq_out}, {16'h0, m_out()});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20417));
        rst_n = 1'b0; irq_in = 32'hFFFF_FFFF; bus_valid = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_size = '0; bus_wdata = '0;
        for (int i = 0; i < 32; i++) m_route[i] = 8'h0;
        m_en = '0; m_pin = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 outputs in reset", {16'h0, irq_out}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        irq_in = 32'h0;
        rst_n = 1'b1;
        @(negedge clk);
        bus_op(1'b0, 7'h24, 2'd2, 0, "R1 enable after reset");
        bus_op(1'b0, 7'h05, 2'd0, 0, "R1 route after reset");

        // R2 route byte round trip
        bus_op(1'b1, 7'h05, 2'd0, 32'h0000_0021, "R2");
        bus_op(1'b0, 7'h05, 2'd0, 0, "R2 route readback");
        bus_op(1'b1, 7'h1F, 2'd0, 32'hFFFF_FF9C, "R2");
        bus_op(1'b0, 7'h1F, 2'd0, 0, "R2 last route readback");

        // R3 non-byte access to route window
        bus_op(1'b1, 7'h04, 2'd2, 32'hFFFF_FFFF, "R3");
        bus_op(1'b1, 7'h06, 2'd1, 32'hFFFF_FFFF, "R3");
        bus_op(1'b0, 7'h04, 2'd0, 0, "R3 route 4 untouched");
        bus_op(1'b0, 7'h06, 2'd0, 0, "R3 route 6 untouched");
        bus_op(1'b0, 7'h04, 2'd2, 0, "R3 word read of route window");

        // R4, R5 enable mask
        bus_op(1'b1, 7'h28, 2'd2, 32'h0000_00F0, "R4");
        bus_op(1'b1, 7'h28, 2'd2, 32'h0000_000F, "R4");
        bus_op(1'b0, 7'h24, 2'd2, 0, "R4 mask after two sets");
        bus_op(1'b1, 7'h2C, 2'd2, 32'h0000_003C, "R5");
        bus_op(1'b0, 7'h24, 2'd2, 0, "R5 mask after clear");

        // R6 masked status
        set_pins(32'h0000_0F0F);
        bus_op(1'b0, 7'h20, 2'd2, 0, "R6 masked status");
        set_pins(32'h0000_0000);
        bus_op(1'b0, 7'h20, 2'd2, 0, "R6 status follows level");

        // R8 core from one input, line from another
        bus_op(1'b1, 7'h24, 2'd2, 0, "R9 write to read-only mask word");
        bus_op(1'b1, 7'h2C, 2'd2, 32'hFFFF_FFFF, "R5");
        bus_op(1'b1, 7'h28, 2'd2, 32'h0000_0088, "R4");
        bus_op(1'b1, 7'h03, 2'd0, 32'h0000_0002, "R2");
        bus_op(1'b1, 7'h07, 2'd0, 32'h0000_0040, "R2");
        set_pins(32'h0000_0008);
        check("R8 core-only input gives no output", {16'h0, irq_out}, 32'h0);
        set_pins(32'h0000_0088);
        check("R8 split core/line pair", {16'h0, irq_out}, 32'h0000_0040);
        bus_op(1'b0, 7'h48, 2'd2, 0, "R7 core 1 status");
        bus_op(1'b0, 7'h40, 2'd2, 0, "R7 core 0 status");

        // R9 misaligned and unmapped
        bus_op(1'b0, 7'h22, 2'd2, 0, "R9 misaligned word");
        bus_op(1'b0, 7'h44, 2'd2, 0, "R9 core window off-stride");
        bus_op(1'b0, 7'h30, 2'd2, 0, "R9 unmapped word");
        bus_op(1'b0, 7'h24, 2'd0, 0, "R9 byte on mask word");
        bus_op(1'b1, 7'h29, 2'd2, 32'hFFFF_FFFF, "R9");
        bus_op(1'b0, 7'h24, 2'd2, 0, "R9 mask after misaligned set");

        // R10 status writes inert
        bus_op(1'b1, 7'h48, 2'd2, 32'h0, "R10");
        bus_op(1'b1, 7'h20, 2'd2, 32'h0, "R10");
        bus_op(1'b0, 7'h48, 2'd2, 0, "R10 core status recomputed");
        bus_op(1'b0, 7'h20, 2'd2, 0, "R10 status recomputed");

        // R11 read data holds during idle
        held = bus_rdata;
        repeat (3) @(negedge clk);
        check("R11 rdata held when idle", bus_rdata, held);

        // random mix
        for (int k = 0; k < 900; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) set_pins($urandom & $urandom);
            else if (r < 4) bus_op(1'b1, 7'($urandom_range(0, 31)), 2'd0, $urandom, "R2 random");
            else if (r == 4) bus_op(1'b1, 7'h28, 2'd2, $urandom & $urandom, "R4 random");
            else if (r == 5) bus_op(1'b1, 7'h2C, 2'd2, $urandom & $urandom, "R5 random");
            else if (r < 9) bus_op(1'b0, 7'($urandom_range(0, 95)), 2'($urandom_range(0, 3)), 0, "R7 random read");
            else bus_op(1'b1, 7'($urandom_range(0, 95)), 2'($urandom_range(0, 3)), $urandom, "R9 random write");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule